// File: doc/BRIEF.md
# Dual-Edge ADC Burst Capture Buffer

This block takes the parallel output of a high-speed ADC that forwards a dual-data-rate clock alongside its data. Each clock edge from the converter coincides with a change on the data lines, so the block never samples on that raw clock. It samples on a copy of the clock shifted by a quarter period, which is generated outside the block. Each edge of that shifted clock lands in the middle of a stable data window. One half-sample is taken on the rising edge and the other half on the falling edge. The two halves are then joined into one full sample word.

A start pulse in the system clock domain arms a capture. The capture side then stores a fixed-length burst of consecutive samples into a local buffer. When the burst is complete, the system side raises a one-cycle done flag. It then offers the samples in capture order on a valid/ready read port.

Both control events cross the clock boundary by toggle handshakes through flop synchronizers. These are the start request and the end-of-burst notice. No single-cycle start pulse is lost this way. A start request is ignored while a burst is being captured or is still waiting to be read out.

Top module: `ddrcap_buffer`

## Requirements
- R1: After reset, `rd_valid` and `done` are both low.
- R2: Each sample word places the half captured on the shifted clock's rising edge in bits [2*HALF_W-1:HALF_W] and the half captured on the following falling edge in bits [HALF_W-1:0].
- R3: A start pulse of one system clock cycle, given while the block is idle, causes exactly BURST samples to be stored and then offered for reading.
- R4: The stored samples are consecutive. Sample k+1 holds the two data beats that immediately follow the two beats of sample k.
- R5: While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold their values. Each cycle with both high moves to the next sample. `rd_valid` goes low after the BURST-th transfer.
- R6: A start pulse given while a capture is in progress or while samples remain unread has no effect. No extra burst and no extra done pulse follow it.
- R7: `done` is high for exactly one system clock cycle per burst, in the same cycle as the first sample is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the control and read port |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cap_clk | input | 1 | Quarter-period-shifted copy of the ADC forwarded clock |
| adc_half | input | HALF_W | ADC data lines, one half-sample per clock edge |
| start | input | 1 | Capture request pulse (sys_clk domain) |
| done | output | 1 | One-cycle pulse when a full burst is ready |
| rd_valid | output | 1 | A stored sample is offered on rd_data |
| rd_ready | input | 1 | Consumer accepts the offered sample |
| rd_data | output | 2*HALF_W | Offered sample word, rising-edge half in the upper bits |

## Verification
The bench builds the block with HALF_W = 4 and BURST = 8. With a 4-bit half, the ramp wraps inside a single burst, so the modulo step between samples is checked as well as the plain increment. The short burst makes the last buffer index, the drop of `rd_valid` after the final transfer, and several back-to-back bursts all reachable in a short run. The capture clock is 125 MHz and unrelated to the system clock, so both synchronizer paths are exercised with a drifting phase between the domains.

// File: rtl/ddrcap_pkg.sv
`timescale 1ns/1ps
package ddrcap_pkg;
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_WAIT  = 2'd1,
        RD_DRAIN = 2'd2
    } rd_state_e;
endpackage

// File: rtl/ddrcap_sync.sv
`timescale 1ns/1ps
module ddrcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ddrcap_iddr.sv
`timescale 1ns/1ps
module ddrcap_iddr #(
    parameter int HALF_W = 7
) (
    input  logic                cap_clk,
    input  logic                rst_n,
    input  logic [HALF_W-1:0]   pin_data,
    output logic [2*HALF_W-1:0] pair_word
);
    logic [HALF_W-1:0] rise_d, rise_q;
    logic [HALF_W-1:0] fall_d, fall_q;

    always_comb begin
        rise_d = pin_data;
        fall_d = pin_data;
    end

    // rising-edge half
    always_ff @(posedge cap_clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= rise_d;
    end

    // falling-edge half
    always_ff @(negedge cap_clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= fall_d;
    end

    // at the next rising edge both halves belong to one sample, rising first
    assign pair_word = {rise_q, fall_q};
endmodule

// File: rtl/ddrcap_store.sv
`timescale 1ns/1ps
module ddrcap_store #(
    parameter int HALF_W = 7,
    parameter int BURST  = 32
) (
    input  logic                     cap_clk,
    input  logic                     rst_n,
    input  logic                     req_tgl_s,
    input  logic [2*HALF_W-1:0]      pair_word,
    input  logic [$clog2(BURST)-1:0] rd_addr,
    output logic [2*HALF_W-1:0]      rd_word,
    output logic                     done_tgl
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int IDX_W  = $clog2(BURST);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BURST - 1);

    typedef struct packed {
        logic             seen;
        logic             active;
        logic [IDX_W-1:0] idx;
        logic             done_tgl;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic      we;
    logic [WORD_W-1:0] mem_q [BURST];

    always_comb begin
        st_d = st_q;
        we   = 1'b0;
        if (st_q.active) begin
            we = 1'b1;
            if (st_q.idx == LAST) begin
                st_d.active   = 1'b0;
                st_d.done_tgl = ~st_q.done_tgl;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (req_tgl_s != st_q.seen) begin
            st_d.seen   = req_tgl_s;
            st_d.active = 1'b1;
            st_d.idx    = '0;
        end
    end

    always_ff @(posedge cap_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge cap_clk) begin
        if (we) mem_q[st_q.idx] <= pair_word;
    end

    assign rd_word  = mem_q[rd_addr];
    assign done_tgl = st_q.done_tgl;

    // R3: a running capture never writes outside the burst
    assert_wr_in_range_R3: assert property (@(posedge cap_clk) disable iff (!rst_n)
        st_q.active |-> (st_q.idx <= LAST));
    // R3: the end-of-burst toggle only moves when a burst closes
    assert_done_on_close_R3: assert property (@(posedge cap_clk) disable iff (!rst_n)
        (st_q.done_tgl != st_d.done_tgl) |-> (st_q.active && st_q.idx == LAST));
endmodule

// File: rtl/ddrcap_buffer.sv
`timescale 1ns/1ps
module ddrcap_buffer
    import ddrcap_pkg::*;
#(
    parameter int HALF_W      = 7,
    parameter int BURST       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                sys_clk,
    input  logic                rst_n,
    input  logic                cap_clk,
    input  logic [HALF_W-1:0]   adc_half,
    input  logic                start,
    output logic                done,
    output logic                rd_valid,
    input  logic                rd_ready,
    output logic [2*HALF_W-1:0] rd_data
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int IDX_W  = $clog2(BURST);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BURST - 1);

    typedef struct packed {
        rd_state_e        st;
        logic             req_tgl;
        logic             done_seen;
        logic [IDX_W-1:0] rd_idx;
        logic             done_p;
    } sys_state_t;

    sys_state_t s_d, s_q;
    logic req_tgl_s, done_tgl_c, done_tgl_s;
    logic [WORD_W-1:0] pair_word, rd_word;

    ddrcap_iddr #(.HALF_W(HALF_W)) u_iddr (
        .cap_clk(cap_clk), .rst_n(rst_n), .pin_data(adc_half), .pair_word(pair_word)
    );

    ddrcap_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(cap_clk), .rst_n(rst_n), .d(s_q.req_tgl), .q(req_tgl_s)
    );

    ddrcap_store #(.HALF_W(HALF_W), .BURST(BURST)) u_store (
        .cap_clk(cap_clk), .rst_n(rst_n), .req_tgl_s(req_tgl_s),
        .pair_word(pair_word), .rd_addr(s_q.rd_idx), .rd_word(rd_word),
        .done_tgl(done_tgl_c)
    );

    ddrcap_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk(sys_clk), .rst_n(rst_n), .d(done_tgl_c), .q(done_tgl_s)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done_p = 1'b0;
        unique case (s_q.st)
            RD_IDLE: if (start) begin
                s_d.req_tgl = ~s_q.req_tgl;
                s_d.st      = RD_WAIT;
            end
            RD_WAIT: if (done_tgl_s != s_q.done_seen) begin
                s_d.done_seen = done_tgl_s;
                s_d.rd_idx    = '0;
                s_d.done_p    = 1'b1;
                s_d.st        = RD_DRAIN;
            end
            RD_DRAIN: if (rd_ready) begin
                if (s_q.rd_idx == LAST) s_d.st = RD_IDLE;
                else                    s_d.rd_idx = s_q.rd_idx + 1'b1;
            end
            default: s_d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: RD_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign done     = s_q.done_p;
    assign rd_valid = (s_q.st == RD_DRAIN);
    assign rd_data  = rd_word;

    // R5: an offered sample holds until it is taken
    assert_hold_on_stall_R5: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    // R6: no new request leaves while a burst is outstanding
    assert_no_rearm_busy_R6: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (s_q.st != RD_IDLE) |=> $stable(s_q.req_tgl));
    // R7: done lasts one cycle and arrives with the first offered sample
    assert_done_pulse_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_with_valid_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
        done |-> (rd_valid && s_q.rd_idx == '0));
endmodule

// File: tb/ddrcap_buffer_bench.sv
`timescale 1ns/1ps
module ddrcap_buffer_bench;
    localparam int HALF_W = 4;
    localparam int BURST  = 8;
    localparam int WORD_W = 2 * HALF_W;
    localparam int MODV   = 1 << HALF_W;

    logic sys_clk = 1'b0;
    logic raw_clk = 1'b0;
    logic cap_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic [HALF_W-1:0] adc_half = '0;
    logic start = 1'b0;
    logic rd_ready = 1'b0;
    logic done, rd_valid;
    logic [WORD_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int beat = 0;

    ddrcap_buffer #(.HALF_W(HALF_W), .BURST(BURST)) u_ddrcap_buffer (
        .sys_clk(sys_clk), .rst_n(rst_n), .cap_clk(cap_clk), .adc_half(adc_half),
        .start(start), .done(done), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data)
    );

    // 200 MHz system clock
    always #2.5 sys_clk = ~sys_clk;

    // forwarded 125 MHz DDR clock: data changes on each of its edges (ramp)
    initial begin
        forever begin
            raw_clk = 1'b1; adc_half = HALF_W'(beat); beat++;
            #4;
            raw_clk = 1'b0; adc_half = HALF_W'(beat); beat++;
            #4;
        end
    end

    // quarter-period shifted copy used for capture
    initial begin
        #2;
        forever begin
            cap_clk = 1'b1; #4;
            cap_clk = 1'b0; #4;
        end
    end

    always @(negedge sys_clk) if (rst_n && done) done_cnt++;

    task automatic chk(input bit ok, input string req, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    task automatic pulse_start();
        @(negedge sys_clk); start = 1'b1;
        @(negedge sys_clk); start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int base = done_cnt;
        int t = 0;
        while (done_cnt == base && t < 400) begin @(negedge sys_clk); t++; end
        chk(done_cnt == base + 1, req,
            $sformatf("done pulses actual %0d expected %0d", done_cnt - base, 1));
    endtask

    // drain n samples; stall on every other offer when stall is set
    task automatic read_n(input int n, input bit stall, input bit first, inout int prev_hi);
        int got = 0;
        int t = 0;
        bit held = 1'b0;
        logic [WORD_W-1:0] held_v = '0;
        while (got < n && t < 400) begin
            @(negedge sys_clk); t++;
            if (held) begin
                chk(rd_valid && rd_data == held_v, "R5",
                    $sformatf("stalled data actual %0h expected %0h", rd_data, held_v));
                held = 1'b0;
            end
            if (rd_valid) begin
                if (stall && (t % 2 == 0) && !held) begin
                    rd_ready = 1'b0; held = 1'b1; held_v = rd_data;
                end else begin
                    int hi = int'(rd_data[WORD_W-1:HALF_W]);
                    int lo = int'(rd_data[HALF_W-1:0]);
                    rd_ready = 1'b1;
                    chk(lo == (hi + 1) % MODV && hi % 2 == 0, "R2",
                        $sformatf("halves actual %0h/%0h expected %0h/%0h",
                                  hi, lo, hi - hi % 2, (hi - hi % 2 + 1) % MODV));
                    if (!(first && got == 0))
                        chk(hi == (prev_hi + 2) % MODV, "R4",
                            $sformatf("upper half actual %0h expected %0h", hi, (prev_hi + 2) % MODV));
                    prev_hi = hi;
                    got++;
                end
            end else begin
                rd_ready = 1'b0;
            end
        end
        @(negedge sys_clk); rd_ready = 1'b0;
        chk(got == n, "R3", $sformatf("samples read actual %0d expected %0d", got, n));
    endtask

    task automatic test_reset();
        @(negedge sys_clk);
        chk(rd_valid == 1'b0, "R1", $sformatf("rd_valid actual %0b expected 0", rd_valid));
        chk(done == 1'b0, "R1", $sformatf("done actual %0b expected 0", done));
    endtask

    task automatic test_burst(input bit stall);
        int prev_hi = 0;
        pulse_start();
        wait_done("R7");
        chk(rd_valid == 1'b1, "R7", $sformatf("rd_valid with done actual %0b expected 1", rd_valid));
        read_n(BURST, stall, 1'b1, prev_hi);
        chk(rd_valid == 1'b0, "R5", $sformatf("rd_valid after burst actual %0b expected 0", rd_valid));
    endtask

    task automatic test_start_while_capturing();
        int prev_hi = 0;
        int base;
        pulse_start();
        base = done_cnt;
        repeat (2) @(negedge sys_clk);
        pulse_start();
        wait_done("R6");
        read_n(BURST, 1'b0, 1'b1, prev_hi);
        repeat (150) @(negedge sys_clk);
        chk(done_cnt == base + 1, "R6",
            $sformatf("bursts after extra start actual %0d expected 1", done_cnt - base));
        chk(rd_valid == 1'b0, "R6", $sformatf("rd_valid actual %0b expected 0", rd_valid));
    endtask

    task automatic test_start_while_draining();
        int prev_hi = 0;
        int base;
        pulse_start();
        wait_done("R3");
        base = done_cnt;
        read_n(BURST / 2, 1'b0, 1'b1, prev_hi);
        pulse_start();
        read_n(BURST - BURST / 2, 1'b0, 1'b0, prev_hi);
        repeat (150) @(negedge sys_clk);
        chk(done_cnt == base, "R6",
            $sformatf("done after drain-time start actual %0d expected 0", done_cnt - base));
        chk(rd_valid == 1'b0, "R6", $sformatf("rd_valid actual %0b expected 0", rd_valid));
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge sys_clk);
        test_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge sys_clk);
        test_reset();
        test_burst(1'b0);
        test_burst(1'b1);
        test_start_while_capturing();
        test_start_while_draining();
        test_burst(1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule